// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that were hoisted ahead of stores that might alias them. Each advanced load puts an entry into a fully associative table. The entry holds the load's destination register id, its physical byte address and its access size. Every store probes the table by address. Any entry whose byte range overlaps the store's bytes is dropped. Later, a check operation asks by register id whether the load's entry is still present. A present entry means no aliasing store hit the loaded bytes, so the speculation stands. A missing entry tells the pipeline to redo the load.

Each cycle the table accepts two load insertions, two store probes and one check. Several rules fix how these interact within one cycle:
- The check sees the table as it stood at the start of the cycle.
- A clearing check is resolved before the cycle's insertions.
- Insertion port 0 is older than port 1.
- All insertions are older than the stores of the same cycle.

When no slot is free, a round-robin pointer picks the entry to evict. The evicted load will then fail its check.

Top module: `spec_load_table`

## Requirements
- R1: After synchronous active-high reset the table holds no valid entry, `chk_done` and `chk_ok` are 0, and the replacement pointer is at slot 0.
- R2: A check raised in cycle t gives `chk_done`=1 in cycle t+1. In that same cycle t+1, `chk_ok`=1 exactly when the table held a valid entry with `chk_rid` at the start of cycle t. Insertions and stores of cycle t are not visible to that check.
- R3: An insertion records register id, address and size, and a check issued in a later cycle finds it.
- R4: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A store removes every entry whose byte range [pa, pa+size) overlaps its own range. A store touching only adjacent bytes leaves the entry in place.
- R5: Inserting a register id that already has a valid entry overwrites that entry's address and size, so only the new range is probed.
- R6: Two insertions can occur in one cycle. If both carry the same register id, port 1's address survives.
- R7: Two store probes in one cycle both take effect.
- R8: An insertion that matches no register id takes the lowest-numbered free slot. When no slot is free it takes the slot under the round-robin pointer, which then advances by one and wraps after the last slot. The evicted register id then misses its check.
- R9: A store that overlaps an insertion made in the same cycle removes the new entry.
- R10: A check with `chk_clr`=1 that hits removes the entry. A check with `chk_clr`=0 leaves the entry in place. A clearing check that misses changes nothing.
- R11: A clearing check and an insertion of the same register id in one cycle leave the new entry valid.
- R12: At no time do two valid entries hold the same register id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_vld | input | LD_PORTS | Insertion request per load port |
| ld_rid | input | LD_PORTS x 7 | Destination register id per load port |
| ld_pa | input | LD_PORTS x 40 | Physical byte address per load port |
| ld_sz | input | LD_PORTS x 2 | Access size code per load port |
| st_vld | input | ST_PORTS | Store probe request per store port |
| st_pa | input | ST_PORTS x 40 | Store physical byte address |
| st_sz | input | ST_PORTS x 2 | Store access size code |
| chk_vld | input | 1 | Check request |
| chk_clr | input | 1 | Check removes the entry on a hit |
| chk_rid | input | 7 | Register id being checked |
| chk_done | output | 1 | Check result is valid this cycle |
| chk_ok | output | 1 | Checked load is still valid |

## Verification
A check answer appears exactly one cycle after the request. Table changes made by that cycle's insertions, stores and clearing checks first become visible to a check issued in the next cycle, so they show up two cycles after the stimulus. The bench runs a behavioural model of the table and steps it at each stimulus. From the model's state before the update it fixes the expected answer, then reads `chk_done` and `chk_ok` at the falling edge after the next rising edge. The comparison happens in every cycle, across directed sequences and a long pseudo-random phase in which 40 register ids compete for 32 slots.

// File: rtl/slat_pkg.sv
package slat_pkg;

    localparam int RID_W = 7;
    localparam int PA_W  = 40;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_sz_e;

    typedef struct packed {
        logic             vld;
        logic [RID_W-1:0] rid;
        logic [PA_W-1:0]  pa;
        acc_sz_e          sz;
    } slot_t;

    // One past the last byte touched, one bit wider so it cannot wrap.
    function automatic logic [PA_W:0] span_end(input logic [PA_W-1:0] pa, input acc_sz_e sz);
        logic [1:0] s;
        s = sz;
        return {1'b0, pa} + ((PA_W+1)'(1) << s);
    endfunction

    function automatic logic spans_overlap(input logic [PA_W-1:0] pa_a, input acc_sz_e sz_a,
                                           input logic [PA_W-1:0] pa_b, input acc_sz_e sz_b);
        return ({1'b0, pa_a} < span_end(pa_b, sz_b)) && ({1'b0, pa_b} < span_end(pa_a, sz_a));
    endfunction

endpackage

// File: rtl/slat_probe.sv
module slat_probe import slat_pkg::*; #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  slot_t [ENTRIES-1:0] view_i,
    input  logic [RID_W-1:0]    rid_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (view_i[e].vld && view_i[e].rid == rid_i) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(e);
            end
        end
    end
endmodule

// File: rtl/slat_alloc.sv
module slat_alloc import slat_pkg::*; #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  slot_t [ENTRIES-1:0] view_i,
    input  logic                req_vld_i,
    input  logic [RID_W-1:0]    req_rid_i,
    input  logic [IDX_W-1:0]    ptr_i,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [IDX_W-1:0]    ptr_o
);
    logic             same_hit;
    logic [IDX_W-1:0] same_idx;
    logic             free_hit;
    logic [IDX_W-1:0] free_idx;

    slat_probe #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_same (
        .view_i (view_i),
        .rid_i  (req_rid_i),
        .hit_o  (same_hit),
        .idx_o  (same_idx)
    );

    // Descending scan so the lowest free slot is the one kept.
    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!view_i[e].vld) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(e);
            end
        end
    end

    always_comb begin
        wr_en_o  = req_vld_i;
        ptr_o    = ptr_i;
        if (same_hit) begin
            wr_idx_o = same_idx;
        end else if (free_hit) begin
            wr_idx_o = free_idx;
        end else begin
            wr_idx_o = ptr_i;
            if (req_vld_i) begin
                ptr_o = (ptr_i == IDX_W'(ENTRIES - 1)) ? '0 : ptr_i + 1'b1;
            end
        end
    end
endmodule

// File: rtl/slat_store_kill.sv
module slat_store_kill import slat_pkg::*; #(
    parameter int ENTRIES  = 32,
    parameter int ST_PORTS = 2
) (
    input  slot_t [ENTRIES-1:0]              view_i,
    input  logic  [ST_PORTS-1:0]             st_vld_i,
    input  logic  [ST_PORTS-1:0][PA_W-1:0]   st_pa_i,
    input  logic  [ST_PORTS-1:0][1:0]        st_sz_i,
    output logic  [ENTRIES-1:0]              kill_o
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_comb begin
            kill_o[e] = 1'b0;
            for (int p = 0; p < ST_PORTS; p++) begin
                if (st_vld_i[p] && view_i[e].vld &&
                    spans_overlap(view_i[e].pa, view_i[e].sz, st_pa_i[p], acc_sz_e'(st_sz_i[p]))) begin
                    kill_o[e] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table import slat_pkg::*; #(
    parameter int ENTRIES  = 32,
    parameter int LD_PORTS = 2,
    parameter int ST_PORTS = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [LD_PORTS-1:0]            ld_vld,
    input  logic [LD_PORTS-1:0][RID_W-1:0] ld_rid,
    input  logic [LD_PORTS-1:0][PA_W-1:0]  ld_pa,
    input  logic [LD_PORTS-1:0][1:0]       ld_sz,
    input  logic [ST_PORTS-1:0]            st_vld,
    input  logic [ST_PORTS-1:0][PA_W-1:0]  st_pa,
    input  logic [ST_PORTS-1:0][1:0]       st_sz,
    input  logic                           chk_vld,
    input  logic                           chk_clr,
    input  logic [RID_W-1:0]               chk_rid,
    output logic                           chk_done,
    output logic                           chk_ok
);
    localparam int IDX_W = $clog2(ENTRIES);

    slot_t [ENTRIES-1:0] tbl_q;
    slot_t [ENTRIES-1:0] tbl_d;
    slot_t [ENTRIES-1:0] stage_v [0:LD_PORTS];
    logic  [IDX_W-1:0]   ptr_q;
    logic  [IDX_W-1:0]   ptr_c   [0:LD_PORTS];

    logic                probe_hit;
    logic  [IDX_W-1:0]   probe_idx;
    logic  [LD_PORTS-1:0] wr_en;
    logic  [IDX_W-1:0]   wr_idx  [0:LD_PORTS-1];
    logic  [IDX_W-1:0]   ptr_nx  [0:LD_PORTS-1];
    logic  [ENTRIES-1:0] kill;

    // Check sees the start-of-cycle table.
    slat_probe #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_probe (
        .view_i (tbl_q),
        .rid_i  (chk_rid),
        .hit_o  (probe_hit),
        .idx_o  (probe_idx)
    );

    // Each insertion port sees the table as left by the older ones.
    for (genvar p = 0; p < LD_PORTS; p++) begin : g_ld
        slat_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
            .view_i    (stage_v[p]),
            .req_vld_i (ld_vld[p]),
            .req_rid_i (ld_rid[p]),
            .ptr_i     (ptr_c[p]),
            .wr_en_o   (wr_en[p]),
            .wr_idx_o  (wr_idx[p]),
            .ptr_o     (ptr_nx[p])
        );
    end

    // Order inside a cycle: clearing check, load port 0, load port 1.
    always_comb begin
        stage_v[0] = tbl_q;
        ptr_c[0]   = ptr_q;
        if (chk_vld && chk_clr && probe_hit) begin
            stage_v[0][probe_idx].vld = 1'b0;
        end
        for (int p = 0; p < LD_PORTS; p++) begin
            stage_v[p+1] = stage_v[p];
            ptr_c[p+1]   = ptr_nx[p];
            if (wr_en[p]) begin
                stage_v[p+1][wr_idx[p]].vld = 1'b1;
                stage_v[p+1][wr_idx[p]].rid = ld_rid[p];
                stage_v[p+1][wr_idx[p]].pa  = ld_pa[p];
                stage_v[p+1][wr_idx[p]].sz  = acc_sz_e'(ld_sz[p]);
            end
        end
    end

    // Stores come last, so they also hit this cycle's insertions.
    slat_store_kill #(.ENTRIES(ENTRIES), .ST_PORTS(ST_PORTS)) u_kill (
        .view_i   (stage_v[LD_PORTS]),
        .st_vld_i (st_vld),
        .st_pa_i  (st_pa),
        .st_sz_i  (st_sz),
        .kill_o   (kill)
    );

    always_comb begin
        tbl_d = stage_v[LD_PORTS];
        for (int e = 0; e < ENTRIES; e++) begin
            if (kill[e]) tbl_d[e].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) tbl_q[e] <= '0;
            ptr_q    <= '0;
            chk_done <= 1'b0;
            chk_ok   <= 1'b0;
        end else begin
            tbl_q    <= tbl_d;
            ptr_q    <= ptr_c[LD_PORTS];
            chk_done <= chk_vld;
            chk_ok   <= chk_vld && probe_hit;
        end
    end
endmodule

// File: rtl/slat_chk.sv
module slat_chk import slat_pkg::*; #(
    parameter int ENTRIES  = 32,
    parameter int LD_PORTS = 2,
    parameter int ST_PORTS = 2
) (
    input logic                          clk,
    input logic                          rst,
    input slot_t [ENTRIES-1:0]           tbl_q,
    input logic  [LD_PORTS-1:0]          ld_vld,
    input logic  [ST_PORTS-1:0]          st_vld,
    input logic  [ST_PORTS-1:0][PA_W-1:0] st_pa,
    input logic  [ST_PORTS-1:0][1:0]     st_sz,
    input logic                          chk_vld,
    input logic                          chk_clr,
    input logic  [RID_W-1:0]             chk_rid,
    input logic                          chk_done,
    input logic                          chk_ok
);
    logic                          dup_rid;
    logic                          stale;
    logic                          cleared_left;
    logic [ST_PORTS-1:0]           st_vld_q;
    logic [ST_PORTS-1:0][PA_W-1:0] st_pa_q;
    logic [ST_PORTS-1:0][1:0]      st_sz_q;
    logic                          clr_q;
    logic [RID_W-1:0]              clr_rid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_vld_q  <= '0;
            st_pa_q   <= '0;
            st_sz_q   <= '0;
            clr_q     <= 1'b0;
            clr_rid_q <= '0;
        end else begin
            st_vld_q  <= st_vld;
            st_pa_q   <= st_pa;
            st_sz_q   <= st_sz;
            clr_q     <= chk_vld && chk_clr && (ld_vld == '0);
            clr_rid_q <= chk_rid;
        end
    end

    always_comb begin
        dup_rid      = 1'b0;
        stale        = 1'b0;
        cleared_left = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (tbl_q[i].vld && tbl_q[j].vld && tbl_q[i].rid == tbl_q[j].rid) dup_rid = 1'b1;
            end
            for (int p = 0; p < ST_PORTS; p++) begin
                if (st_vld_q[p] && tbl_q[i].vld &&
                    spans_overlap(tbl_q[i].pa, tbl_q[i].sz, st_pa_q[p], acc_sz_e'(st_sz_q[p]))) stale = 1'b1;
            end
            if (clr_q && tbl_q[i].vld && tbl_q[i].rid == clr_rid_q) cleared_left = 1'b1;
        end
    end

    a_r12_unique_rid: assert property (@(posedge clk) disable iff (rst) !dup_rid);
    a_r4_store_leaves_no_overlap: assert property (@(posedge clk) disable iff (rst) !stale);
    a_r10_clear_removes: assert property (@(posedge clk) disable iff (rst) !cleared_left);
    a_r2_done_after_req: assert property (@(posedge clk) disable iff (rst) chk_vld |=> chk_done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst) !chk_vld |=> !chk_done);
    a_r2_ok_needs_done: assert property (@(posedge clk) disable iff (rst) chk_ok |-> chk_done);
endmodule

bind spec_load_table slat_chk #(
    .ENTRIES(ENTRIES), .LD_PORTS(LD_PORTS), .ST_PORTS(ST_PORTS)
) u_chk (
    .clk(clk), .rst(rst), .tbl_q(tbl_q), .ld_vld(ld_vld),
    .st_vld(st_vld), .st_pa(st_pa), .st_sz(st_sz),
    .chk_vld(chk_vld), .chk_clr(chk_clr), .chk_rid(chk_rid),
    .chk_done(chk_done), .chk_ok(chk_ok)
);

// File: tb/spec_load_table_test.sv
module spec_load_table_test;
    localparam int N = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       ld_vld = '0;
    logic [1:0][6:0]  ld_rid = '0;
    logic [1:0][39:0] ld_pa = '0;
    logic [1:0][1:0]  ld_sz = '0;
    logic [1:0]       st_vld = '0;
    logic [1:0][39:0] st_pa = '0;
    logic [1:0][1:0]  st_sz = '0;
    logic             chk_vld = 1'b0;
    logic             chk_clr = 1'b0;
    logic [6:0]       chk_rid = '0;
    logic             chk_done;
    logic             chk_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural model
    bit      m_vld [N];
    int      m_rid [N];
    longint  m_pa  [N];
    int      m_sz  [N];
    int      m_ptr;
    logic [31:0] seed = 32'h1234_5678;

    spec_load_table uut (
        .clk(clk), .rst(rst), .ld_vld(ld_vld), .ld_rid(ld_rid), .ld_pa(ld_pa), .ld_sz(ld_sz),
        .st_vld(st_vld), .st_pa(st_pa), .st_sz(st_sz), .chk_vld(chk_vld), .chk_clr(chk_clr),
        .chk_rid(chk_rid), .chk_done(chk_done), .chk_ok(chk_ok)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int nbytes(input int code);
        return 1 << code;
    endfunction

    function automatic bit touches(input longint a, input int sa, input longint b, input int sb);
        return (a < b + nbytes(sb)) && (b < a + nbytes(sa));
    endfunction

    function automatic int find_rid(input int rid);
        for (int e = 0; e < N; e++) if (m_vld[e] && m_rid[e] == rid) return e;
        return -1;
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic model_step(output bit exp_ok);
        int hit;
        hit = find_rid(int'(chk_rid));
        exp_ok = chk_vld && (hit >= 0);
        if (chk_vld && chk_clr && hit >= 0) m_vld[hit] = 0;
        for (int p = 0; p < 2; p++) begin
            if (ld_vld[p]) begin
                int slot;
                slot = find_rid(int'(ld_rid[p]));
                if (slot < 0) begin
                    for (int e = N - 1; e >= 0; e--) if (!m_vld[e]) slot = e;
                end
                if (slot < 0) begin
                    slot = m_ptr;
                    m_ptr = (m_ptr + 1) % N;
                end
                m_vld[slot] = 1;
                m_rid[slot] = int'(ld_rid[p]);
                m_pa[slot]  = longint'(ld_pa[p]);
                m_sz[slot]  = int'(ld_sz[p]);
            end
        end
        for (int e = 0; e < N; e++) begin
            for (int p = 0; p < 2; p++) begin
                if (st_vld[p] && m_vld[e] && touches(m_pa[e], m_sz[e], longint'(st_pa[p]), int'(st_sz[p])))
                    m_vld[e] = 0;
            end
        end
    endtask

    // One clock: model update, edge, compare at the following falling edge.
    task automatic cyc(input string tag);
        bit exp_ok;
        bit exp_done;
        exp_done = chk_vld;
        model_step(exp_ok);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (chk_done !== exp_done || chk_ok !== exp_ok) begin
            errors++;
            $display("FAIL %s: done/ok actual %b/%b expected %b/%b", tag, chk_done, chk_ok, exp_done, exp_ok);
        end
        ld_vld  = '0;
        st_vld  = '0;
        chk_vld = 1'b0;
        chk_clr = 1'b0;
    endtask

    task automatic put_ld(input int p, input int rid, input longint pa, input int sz);
        ld_vld[p] = 1'b1; ld_rid[p] = 7'(rid); ld_pa[p] = 40'(pa); ld_sz[p] = 2'(sz);
    endtask

    task automatic put_st(input int p, input longint pa, input int sz);
        st_vld[p] = 1'b1; st_pa[p] = 40'(pa); st_sz[p] = 2'(sz);
    endtask

    task automatic put_chk(input int rid, input bit clr);
        chk_vld = 1'b1; chk_rid = 7'(rid); chk_clr = clr;
    endtask

    initial begin
        for (int e = 0; e < N; e++) begin m_vld[e] = 0; m_rid[e] = 0; m_pa[e] = 0; m_sz[e] = 0; end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (chk_done !== 1'b0 || chk_ok !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b/%b expected 0/0", chk_done, chk_ok);
        end
        rst = 1'b0;

        // R1: empty table after reset
        put_chk(0, 0); cyc("R1");
        put_chk(5, 0); cyc("R1");

        // R2/R3: same-cycle check misses, later check hits
        put_ld(0, 3, 64'h100, 2); put_chk(3, 0); cyc("R2");
        put_chk(3, 0); cyc("R3");
        cyc("R2 idle");

        // R4: adjacent store keeps, overlapping store removes
        put_st(0, 64'h104, 0); cyc("R4");
        put_chk(3, 0); cyc("R4 adjacent");
        put_st(1, 64'h0FF, 0); cyc("R4");
        put_chk(3, 0); cyc("R4 adjacent below");
        put_st(0, 64'h103, 1); cyc("R4");
        put_chk(3, 0); cyc("R4 overlap");

        // R6/R7: two inserts, two stores in one cycle
        put_ld(0, 10, 64'h200, 3); put_ld(1, 11, 64'h300, 3); cyc("R6");
        put_chk(10, 0); cyc("R6");
        put_chk(11, 0); cyc("R6");
        put_st(0, 64'h207, 0); put_st(1, 64'h2F8, 3); cyc("R7");
        put_chk(10, 0); cyc("R7");
        put_chk(11, 0); cyc("R7");

        // R5: re-insert overwrites range
        put_ld(0, 20, 64'h400, 2); cyc("R5");
        put_ld(1, 20, 64'h500, 2); cyc("R5");
        put_st(0, 64'h400, 2); cyc("R5");
        put_chk(20, 0); cyc("R5 old range");
        put_st(0, 64'h502, 0); cyc("R5");
        put_chk(20, 0); cyc("R5 new range");

        // R6: same rid on both ports, port 1 wins
        put_ld(0, 30, 64'h600, 1); put_ld(1, 30, 64'h700, 1); cyc("R6");
        put_st(0, 64'h600, 1); cyc("R6");
        put_chk(30, 0); cyc("R6 port1 kept");
        put_st(1, 64'h701, 0); cyc("R6");
        put_chk(30, 0); cyc("R6 port1 killed");

        // R9: same-cycle store kills insertion
        put_ld(0, 40, 64'h800, 2); put_st(0, 64'h802, 0); cyc("R9");
        put_chk(40, 0); cyc("R9");

        // R10: clearing and non-clearing checks
        put_ld(0, 50, 64'h900, 0); cyc("R10");
        put_chk(50, 0); cyc("R10 keep");
        put_chk(50, 0); cyc("R10 keep");
        put_chk(50, 1); cyc("R10 clear");
        put_chk(50, 0); cyc("R10 gone");
        put_chk(50, 1); cyc("R10 clear miss");

        // R11: clear and insert of the same rid
        put_ld(0, 51, 64'hA00, 0); cyc("R11");
        put_chk(51, 1); put_ld(1, 51, 64'hB00, 0); cyc("R11");
        put_chk(51, 0); cyc("R11");

        // R8: overfill then check every rid
        for (int k = 0; k < 40; k++) begin
            put_ld(k % 2, 60 + k, 64'h1000 + 16 * k, 3); cyc("R8 fill");
        end
        for (int r = 0; r < 128; r++) begin
            put_chk(r, 0); cyc("R8 scan");
        end

        // Mixed pseudo-random traffic, all requirements
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = rnd(); b = rnd();
            if (a[0]) put_ld(0, int'(a[7:2]) % 40, 64'h2000 + (a[15:8] % 96), int'(a[17:16]));
            if (a[1]) put_ld(1, int'(b[5:0]) % 40, 64'h2000 + (b[13:6] % 96), int'(b[15:14]));
            if (a[20:18] == 3'd0) put_st(0, 64'h2000 + (a[28:21] % 96), int'(b[17:16]));
            if (b[20:18] == 3'd1) put_st(1, 64'h2000 + (b[28:21] % 96), int'(a[30:29]));
            if (b[29]) put_chk(int'(b[31:26]) % 40, b[30]);
            cyc("R12 random");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule